// File: doc/BRIEF.md
# Popcount-Filling Memory with Button Address Control

This block is a small single-port memory of 128 words, 3 bits each, placed behind an address controller that two push-buttons and one clear switch drive. Holding the fill button down puts the block in fill mode. In that mode a fill counter steps through the addresses on every system clock. Each location it visits is loaded with the number of one bits in its own 7-bit address. For example, address 1000011 receives 011. When the fill button is let go, the block returns to browse mode. The word stored at the browse address is then shown on three data indicators.

The browse address moves forward by one each time the step button is released. Pressing the step button does not move it. The fill and browse addresses come from two separate up counters. The fill button selects which counter drives the memory address. The five low bits of the selected address are shown on five more indicators. The clear switch returns both counters to zero and leaves the stored words untouched.

All button and switch inputs are asynchronous to the clock. Each passes through a two-flop synchronizer. The buttons also pass through a debounce filter before they affect any state.

Top module: `popram_top`

## Requirements
- R1: While `rstN` is low, `addrLed` and `dataLed` are both zero.
- R2: While the debounced `fillBtnN` is low (pressed), each clock writes the popcount of the fill address into that address, and the fill address then increases by one. Holding the button for 128 or more cycles leaves every word equal to the popcount of its address.
- R3: While `fillBtnN` is high (released), `dataLed` shows the word stored at the browse address, with one cycle of read latency.
- R4: Each debounced release of `stepBtnN` (a low-to-high transition) advances the browse address by exactly one.
- R5: Pressing `stepBtnN` and holding it, without releasing it, leaves the browse address unchanged.
- R6: Both counters wrap from 127 to 0.
- R7: While `clrSw` is high, both counters are held at zero, and clear wins over any increment. The stored words are not changed by clear.
- R8: `addrLed` equals bits 4:0 of the selected address: the fill counter in fill mode and the browse counter in browse mode.
- R9: A button level that lasts fewer than `DEB_CYCLES` clocks after synchronization is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fillBtnN | input | 1 | Fill button, low while pressed |
| stepBtnN | input | 1 | Step button, low while pressed; its release advances the browse address |
| clrSw | input | 1 | Clear switch, high clears both counters |
| dataLed | output | 3 | Word read from the selected address |
| addrLed | output | 5 | Low five bits of the selected address |

## Verification
The assertions take the button inputs to be slow human-speed levels.

- A real step release is expected to stay high well beyond the debounce window. Under that assumption, each release produces exactly one single-cycle step strobe.
- The counter properties assume that a strobe and clear can arrive in the same cycle, and that clear then wins.

The bench keeps within these assumptions in three ways:

- It holds every intended press and release for more than `DEB_CYCLES` plus the synchronizer depth.
- It drives deliberate glitches only for fewer cycles than the filter needs.
- It changes the clear switch only while no step release is pending.

// File: rtl/popram_pkg.sv
package popram_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic fillEn;   // fill mode: write enable and fill-counter step
    logic browseStep; // one-cycle pulse on a debounced step release
    logic clr;      // synchronized clear level
  } popStrb_t;

  // Count of one bits in the low nBits of a value.
  function automatic int unsigned onesIn(input logic [31:0] val, input int unsigned nBits);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < nBits; i++) begin
      acc += {31'd0, val[i]};
    end
    return acc;
  endfunction

endpackage

// File: rtl/popram_debounce.sv
module popram_debounce #(
  parameter int unsigned DEB_CYCLES = 16,
  parameter logic        RST_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);

  localparam int unsigned CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);

  logic          syncA;
  logic          syncB;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= RST_VAL;
      syncB   <= RST_VAL;
      level   <= RST_VAL;
      holdCnt <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (syncB == level) begin
        holdCnt <= '0;
      end else if (holdCnt == CW'(DEB_CYCLES - 1)) begin
        level   <= syncB;
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  // R9
  level_follows_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(level) |-> (level == $past(syncB)));

  // R9
  level_needs_full_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(level) |-> ($past(holdCnt) == CW'(DEB_CYCLES - 1)));

endmodule

// File: rtl/popram_ctrl.sv
module popram_ctrl
  import popram_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     fillBtnN,
  input  logic     stepBtnN,
  input  logic     clrSw,
  output popStrb_t strb
);

  logic fillLvl;
  logic stepLvl;
  logic stepHeldQ;
  logic stepPulse;
  logic clrA;
  logic clrB;

  popram_debounce #(.DEB_CYCLES(DEB_CYCLES), .RST_VAL(1'b1)) u_fillDeb (
    .clk(clk), .rstN(rstN), .rawIn(fillBtnN), .level(fillLvl)
  );

  popram_debounce #(.DEB_CYCLES(DEB_CYCLES), .RST_VAL(1'b1)) u_stepDeb (
    .clk(clk), .rstN(rstN), .rawIn(stepBtnN), .level(stepLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepHeldQ <= 1'b0;
      stepPulse <= 1'b0;
      clrA      <= 1'b0;
      clrB      <= 1'b0;
    end else begin
      stepHeldQ <= ~stepLvl;
      stepPulse <= stepHeldQ & stepLvl;
      clrA      <= clrSw;
      clrB      <= clrA;
    end
  end

  always_comb begin
    strb.fillEn     = ~fillLvl;
    strb.browseStep = stepPulse;
    strb.clr        = clrB;
  end

  // R4
  step_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |=> !stepPulse);

  // R5
  step_only_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |-> stepLvl);

endmodule

// File: rtl/popram_dp.sv
module popram_dp
  import popram_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned LED_W  = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  popStrb_t             strb,
  output logic [DATA_W-1:0]    dataOut,
  output logic [LED_W-1:0]     addrLow
);

  localparam int unsigned DATA_W = $clog2(ADDR_W + 1);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned N_CNT  = 2;  // index 0: fill, index 1: browse

  typedef logic [ADDR_W-1:0] addr_t;

  addr_t             cntQ [N_CNT];
  logic [N_CNT-1:0]  cntStep;
  addr_t             selAddr;
  logic [DATA_W-1:0] fillWord;
  logic [DATA_W-1:0] memArr [DEPTH];

  assign cntStep = {strb.browseStep, strb.fillEn};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cntQ[g] <= '0;
      else if (strb.clr)   cntQ[g] <= '0;
      else if (cntStep[g]) cntQ[g] <= cntQ[g] + 1'b1;
    end
  end

  assign selAddr  = strb.fillEn ? cntQ[0] : cntQ[1];
  assign fillWord = DATA_W'(onesIn(32'(selAddr), ADDR_W));
  assign addrLow  = selAddr[LED_W-1:0];

  always_ff @(posedge clk) begin
    if (strb.fillEn) memArr[selAddr] <= fillWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= '0;
    else       dataOut <= memArr[selAddr];
  end

  // R7
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cntQ[0] == '0 && cntQ[1] == '0));

  // R2
  fill_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && !strb.clr) |=> (cntQ[0] == addr_t'($past(cntQ[0]) + 1'b1)));

  // R4
  browse_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.browseStep && !strb.clr) |=> (cntQ[1] == addr_t'($past(cntQ[1]) + 1'b1)));

  // R5
  browse_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.browseStep && !strb.clr) |=> $stable(cntQ[1]));

  // R8
  led_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fillEn |-> (addrLow == cntQ[1][LED_W-1:0]));

endmodule

// File: rtl/popram_top.sv
module popram_top
  import popram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned LED_W      = 5,
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fillBtnN,
  input  logic       stepBtnN,
  input  logic       clrSw,
  output logic [2:0] dataLed,
  output logic [4:0] addrLed
);

  popStrb_t strb;
  logic [$clog2(ADDR_W + 1)-1:0] dataW;
  logic [LED_W-1:0]              addrW;

  popram_ctrl #(.DEB_CYCLES(DEB_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillBtnN(fillBtnN), .stepBtnN(stepBtnN),
    .clrSw(clrSw), .strb(strb)
  );

  popram_dp #(.ADDR_W(ADDR_W), .LED_W(LED_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataOut(dataW), .addrLow(addrW)
  );

  assign dataLed = 3'(dataW);
  assign addrLed = 5'(addrW);

endmodule

// File: tb/sim_popram_top.sv
module sim_popram_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEB        = 4;
  localparam int SETTLE     = DEB + 12;

  logic       clk = 1'b0;
  logic       rstN;
  logic       fillBtnN;
  logic       stepBtnN;
  logic       clrSw;
  logic [2:0] dataLed;
  logic [4:0] addrLed;

  int checks = 0;
  int errors = 0;
  int expAddr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  popram_top #(.ADDR_W(7), .LED_W(5), .DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rstN(rstN), .fillBtnN(fillBtnN), .stepBtnN(stepBtnN),
    .clrSw(clrSw), .dataLed(dataLed), .addrLed(addrLed)
  );

  function automatic int ones7(input int a);
    int n = 0;
    for (int i = 0; i < 7; i++) n += (a >> i) & 1;
    return n;
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkBrowse(input string req);
    chk({req, " addrLed"}, int'(addrLed), expAddr % 32);
    chk({req, " dataLed"}, int'(dataLed), ones7(expAddr));
  endtask

  task automatic stepOnce();
    stepBtnN = 1'b0;
    waitCyc(SETTLE);
    stepBtnN = 1'b1;
    waitCyc(SETTLE);
    expAddr = (expAddr + 1) % 128;
  endtask

  task automatic doClear();
    clrSw = 1'b1;
    waitCyc(6);
    clrSw = 1'b0;
    waitCyc(6);
    expAddr = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; fillBtnN = 1'b1; stepBtnN = 1'b1; clrSw = 1'b0;
    waitCyc(4);
    // R1 reset state
    chk("R1 addrLed", int'(addrLed), 0);
    chk("R1 dataLed", int'(dataLed), 0);
    rstN = 1'b1;
    waitCyc(3);

    // R7 and R8: clear held in fill mode keeps the shown address at zero
    clrSw = 1'b1;
    fillBtnN = 1'b0;
    waitCyc(SETTLE);
    chk("R7 fill clear addrLed", int'(addrLed), 0);
    waitCyc(3);
    chk("R7 fill clear stays zero", int'(addrLed), 0);
    clrSw = 1'b0;
    waitCyc(8);
    // R8: in fill mode the shown address follows the fill counter every cycle
    begin
      int a0;
      a0 = int'(addrLed);
      waitCyc(1);
      chk("R8 fill counter step", int'(addrLed), (a0 + 1) % 32);
      waitCyc(1);
      chk("R8 fill counter step2", int'(addrLed), (a0 + 2) % 32);
    end
    // R2: fill the whole memory
    waitCyc(300);
    fillBtnN = 1'b1;
    waitCyc(SETTLE);

    // R3: browse address still zero
    expAddr = 0;
    checkBrowse("R3 addr0");

    // R5: press without release does not advance
    stepBtnN = 1'b0;
    waitCyc(SETTLE * 2);
    checkBrowse("R5 held press");
    stepBtnN = 1'b1;
    waitCyc(SETTLE);
    expAddr = 1;
    checkBrowse("R4 release advance");

    // R9: short glitches ignored
    for (int k = 0; k < 3; k++) begin
      stepBtnN = 1'b0;
      waitCyc(DEB - 2);
      stepBtnN = 1'b1;
      waitCyc(SETTLE);
      checkBrowse("R9 step glitch");
    end
    fillBtnN = 1'b0;
    waitCyc(DEB - 2);
    fillBtnN = 1'b1;
    waitCyc(SETTLE);
    checkBrowse("R9 fill glitch");

    // R4/R2 random walk through the filled memory
    for (int it = 0; it < 24; it++) begin
      int n;
      n = int'($urandom % 5) + 1;
      for (int j = 0; j < n; j++) stepOnce();
      checkBrowse("R2 R4 random walk");
      if (($urandom % 6) == 0) begin
        doClear();
        checkBrowse("R7 browse clear");
      end
    end

    // R6: walk to 127 then wrap
    doClear();
    for (int j = 0; j < 127; j++) stepOnce();
    checkBrowse("R6 at top");
    chk("R6 top word", int'(dataLed), 7);
    stepOnce();
    chk("R6 wrap addr", int'(addrLed), 0);
    checkBrowse("R6 wrapped");

    // R7: contents survive clears; address 1000011 holds 3
    doClear();
    doClear();
    for (int j = 0; j < 67; j++) stepOnce();
    chk("R7 contents kept 0x43", int'(dataLed), 3);
    checkBrowse("R3 0x43");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule